// File: doc/BRIEF.md
# Timestamp Lease Coherence Manager

This block sits beside a shared cache and keeps a small set of cores coherent by logical time instead of sharer lists. Each tracked line holds a write timestamp, a lease timestamp and a single owner ID. Each core has one program timestamp. A core sends one request at a time with its ID, a line index and an opcode. The block answers with a grant that carries the timestamps the core must adopt from then on.

Reads and lease renewals extend a line's lease past the requester's logical time. A write moves the writer's clock beyond every lease handed out so far and makes it the owner. No invalidation is ever sent to earlier readers: they keep their copies and simply stay in the logical past. The only message besides the grant is a writeback request to a line's current owner. It is raised when another core touches that line, and the grant waits for its acknowledge. The directory needs no sharer vector, so its per-line state grows only with the log of the core count.

Top module: `tsc_lease_mgr`

## Requirements
- R1: After reset every core timestamp and every line's write and lease timestamps are zero, and every line is held by the shared cache. `req_ready` is high and `gnt_valid`, `wb_req` and `ts_err` are low.
- R2: A read (opcode 0) by core c on line l sets pts' = max(pts[c], wts[l]) and rts[l]' = max(rts[l], pts' + LEASE). Core c adopts pts', and the grant carries pts', wts[l] and the new rts[l].
- R3: A lease renewal (opcode 2) follows exactly the timestamp rules of a read.
- R4: A write (opcode 1) sets pts' = max(pts[c], rts[l] + 1). Core c adopts it, the line's wts and rts both become pts', and c becomes the owner. The grant carries pts' in all three timestamp fields.
- R5: A request of any opcode on a line owned by a different core first raises `wb_req` with that owner's ID and the line index, and holds them until `wb_ack`. When the acknowledge arrives, the line's wts becomes the owner's timestamp and its rts becomes max(rts, owner timestamp). A read or renewal then releases ownership to the shared cache, and a write transfers it to the requester. The grant follows.
- R6: A request on an unowned line, or on a line the requester owns, completes with no writeback. No other core is ever signalled as a result of a write.
- R7: `req_ready` is high only while idle, and one request is in flight at a time. Without a writeback, `gnt_valid` pulses for one cycle, one cycle after acceptance. With a writeback, it pulses one cycle after the acknowledge is sampled.
- R8: A timestamp sum that exceeds 16 bits saturates at 65535 and sets `ts_err`, which stays set until reset.
- R9: A core's timestamp never decreases, and a line's lease timestamp is never below its write timestamp.
- R10: Owner ID all-ones means the shared cache holds the line, and `wb_req` is never issued to that ID or to the requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_core | input | 3 | Requesting core ID |
| req_line | input | 3 | Tracked line index |
| req_op | input | 2 | 0 read, 1 write, 2 lease renewal |
| wb_req | output | 1 | Writeback request to current owner |
| wb_core | output | 3 | Owner that must write back |
| wb_line | output | 3 | Line to write back |
| wb_ack | input | 1 | Owner has written the line back |
| gnt_valid | output | 1 | Grant pulse |
| gnt_core | output | 3 | Core the grant is for |
| gnt_pts | output | 16 | Timestamp the core must adopt |
| gnt_wts | output | 16 | Line write timestamp |
| gnt_rts | output | 16 | Line lease timestamp |
| ts_err | output | 1 | Sticky timestamp overflow flag |

## Verification
The in-RTL assertions check the protocol shape on every cycle. They cover a writeback request held stable until its acknowledge, the grant following the acknowledge, single-cycle grant pulses with one request outstanding, and a sticky error flag. They also cover monotonic core clocks, lease never below write timestamp, and read grants whose lease lies ahead of the granted time. Only the bench's scenarios show the actual timestamp values. These include the zero state after reset, several readers followed by a writer that jumps past their leases, and a later reader being pulled forward through a writeback. They also include a write that steals ownership, owner self-access with no writeback, and a long write/read climb that ends in saturation.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RENEW = 2'd2
  } tsc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_GNT  = 2'd2
  } tsc_state_e;
endpackage

// File: rtl/tsc_core_clk.sv
module tsc_core_clk #(
  parameter int NUM_CORES = 4,
  parameter int CID_W     = 3,
  parameter int TS_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CID_W-1:0] rd_core,
  output logic [TS_W-1:0]  rd_pts,
  input  logic [CID_W-1:0] own_core,
  output logic [TS_W-1:0]  own_pts,
  input  logic             we,
  input  logic [CID_W-1:0] wr_core,
  input  logic [TS_W-1:0]  wr_pts
);
  logic [TS_W-1:0] pts_q [NUM_CORES];

  always_comb begin
    rd_pts  = '0;
    own_pts = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (rd_core == CID_W'(i))  rd_pts  = pts_q[i];
      if (own_core == CID_W'(i)) own_pts = pts_q[i];
    end
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
    logic en;
    assign en = we && (wr_core == CID_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pts_q[g] <= '0;
      else if (en) pts_q[g] <= wr_pts;
    end

    AST_PTS_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
      en |-> (wr_pts >= pts_q[g])); // R9
  end
endmodule

// File: rtl/tsc_line_dir.sv
module tsc_line_dir #(
  parameter int NUM_LINES = 8,
  parameter int LID_W     = 3,
  parameter int CID_W     = 3,
  parameter int TS_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LID_W-1:0] rd_line,
  output logic [TS_W-1:0]  rd_wts,
  output logic [TS_W-1:0]  rd_rts,
  output logic [CID_W-1:0] rd_own,
  input  logic             we,
  input  logic [LID_W-1:0] wr_line,
  input  logic [TS_W-1:0]  wr_wts,
  input  logic [TS_W-1:0]  wr_rts,
  input  logic [CID_W-1:0] wr_own
);
  localparam logic [CID_W-1:0] HOME = '1;

  logic [TS_W-1:0]  wts_q [NUM_LINES];
  logic [TS_W-1:0]  rts_q [NUM_LINES];
  logic [CID_W-1:0] own_q [NUM_LINES];

  always_comb begin
    rd_wts = '0;
    rd_rts = '0;
    rd_own = HOME;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (rd_line == LID_W'(i)) begin
        rd_wts = wts_q[i];
        rd_rts = rts_q[i];
        rd_own = own_q[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic en;
    assign en = we && (wr_line == LID_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wts_q[g] <= '0;
        rts_q[g] <= '0;
        own_q[g] <= HOME;
      end else if (en) begin
        wts_q[g] <= wr_wts;
        rts_q[g] <= wr_rts;
        own_q[g] <= wr_own;
      end
    end
  end

  AST_LEASE_NOT_BELOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wr_rts >= wr_wts)); // R9
endmodule

// File: rtl/tsc_ts_calc.sv
module tsc_ts_calc #(
  parameter int TS_W  = 16,
  parameter int LEASE = 10
) (
  input  logic            is_write,
  input  logic            merge_wb,
  input  logic [TS_W-1:0] core_pts,
  input  logic [TS_W-1:0] owner_pts,
  input  logic [TS_W-1:0] line_wts,
  input  logic [TS_W-1:0] line_rts,
  output logic [TS_W-1:0] new_pts,
  output logic [TS_W-1:0] new_wts,
  output logic [TS_W-1:0] new_rts,
  output logic            ovf
);
  localparam logic [TS_W:0] LEASE_EXT = (TS_W+1)'(LEASE);
  localparam logic [TS_W:0] TOP       = {1'b0, {TS_W{1'b1}}};

  logic [TS_W-1:0] eff_wts, eff_rts, rd_pts, rd_lease, wr_floor;
  logic [TS_W:0]   lease_sum, bump_sum;
  logic            lease_ovf, bump_ovf;

  always_comb begin
    eff_wts = merge_wb ? owner_pts : line_wts;
    eff_rts = line_rts;
    if (merge_wb && owner_pts > line_rts) eff_rts = owner_pts;

    rd_pts    = (core_pts > eff_wts) ? core_pts : eff_wts;
    lease_sum = {1'b0, rd_pts} + LEASE_EXT;
    lease_ovf = lease_sum > TOP;
    rd_lease  = lease_ovf ? {TS_W{1'b1}} : lease_sum[TS_W-1:0];

    bump_sum  = {1'b0, eff_rts} + (TS_W+1)'(1);
    bump_ovf  = bump_sum > TOP;
    wr_floor  = bump_ovf ? {TS_W{1'b1}} : bump_sum[TS_W-1:0];

    if (is_write) begin
      new_pts = (core_pts > wr_floor) ? core_pts : wr_floor;
      new_wts = new_pts;
      new_rts = new_pts;
      ovf     = bump_ovf;
    end else begin
      new_pts = rd_pts;
      new_wts = eff_wts;
      new_rts = (eff_rts > rd_lease) ? eff_rts : rd_lease;
      ovf     = lease_ovf;
    end
  end
endmodule

// File: rtl/tsc_lease_mgr.sv
module tsc_lease_mgr
  import tsc_pkg::*;
#(
  parameter  int NUM_CORES = 4,
  parameter  int NUM_LINES = 8,
  parameter  int TS_W      = 16,
  parameter  int LEASE     = 10,
  localparam int CID_W     = $clog2(NUM_CORES + 1),
  localparam int LID_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CID_W-1:0] req_core,
  input  logic [LID_W-1:0] req_line,
  input  logic [1:0]       req_op,
  output logic             wb_req,
  output logic [CID_W-1:0] wb_core,
  output logic [LID_W-1:0] wb_line,
  input  logic             wb_ack,
  output logic             gnt_valid,
  output logic [CID_W-1:0] gnt_core,
  output logic [TS_W-1:0]  gnt_pts,
  output logic [TS_W-1:0]  gnt_wts,
  output logic [TS_W-1:0]  gnt_rts,
  output logic             ts_err
);
  localparam logic [CID_W-1:0] HOME = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  tsc_state_e       state_q, state_d;
  logic [CID_W-1:0] core_q, core_d, owner_q, owner_d;
  logic [LID_W-1:0] line_q, line_d;
  logic [1:0]       op_q, op_d;
  logic [TS_W-1:0]  gpts_q, gwts_q, grts_q;
  logic             err_q;

  logic             accept, commit, merge_wb, need_wb, is_write;
  logic [CID_W-1:0] sel_core, line_own_nxt;
  logic [LID_W-1:0] sel_line;
  logic [TS_W-1:0]  cur_pts, own_pts, cur_wts, cur_rts;
  logic [CID_W-1:0] cur_own;
  logic [TS_W-1:0]  nx_pts, nx_wts, nx_rts;
  logic             nx_ovf;

  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign sel_core = (state_q == ST_IDLE) ? req_core : core_q;
  assign sel_line = (state_q == ST_IDLE) ? req_line : line_q;
  assign is_write = ((state_q == ST_IDLE) ? req_op : op_q) == OP_WRITE;
  assign need_wb  = (cur_own != HOME) && (cur_own != req_core);

  tsc_core_clk #(.NUM_CORES(NUM_CORES), .CID_W(CID_W), .TS_W(TS_W)) u_core_clk (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .rd_core  (sel_core),
    .rd_pts   (cur_pts),
    .own_core (owner_q),
    .own_pts  (own_pts),
    .we       (commit),
    .wr_core  (sel_core),
    .wr_pts   (nx_pts)
  );

  tsc_line_dir #(.NUM_LINES(NUM_LINES), .LID_W(LID_W), .CID_W(CID_W), .TS_W(TS_W)) u_line_dir (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .rd_line (sel_line),
    .rd_wts  (cur_wts),
    .rd_rts  (cur_rts),
    .rd_own  (cur_own),
    .we      (commit),
    .wr_line (sel_line),
    .wr_wts  (nx_wts),
    .wr_rts  (nx_rts),
    .wr_own  (line_own_nxt)
  );

  tsc_ts_calc #(.TS_W(TS_W), .LEASE(LEASE)) u_ts_calc (
    .is_write  (is_write),
    .merge_wb  (merge_wb),
    .core_pts  (cur_pts),
    .owner_pts (own_pts),
    .line_wts  (cur_wts),
    .line_rts  (cur_rts),
    .new_pts   (nx_pts),
    .new_wts   (nx_wts),
    .new_rts   (nx_rts),
    .ovf       (nx_ovf)
  );

  always_comb begin
    if (is_write)      line_own_nxt = sel_core;
    else if (merge_wb) line_own_nxt = HOME;
    else               line_own_nxt = cur_own;
  end

  // next-state
  always_comb begin
    state_d  = state_q;
    core_d   = core_q;
    line_d   = line_q;
    op_d     = op_q;
    owner_d  = owner_q;
    commit   = 1'b0;
    merge_wb = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          core_d = req_core;
          line_d = req_line;
          op_d   = req_op;
          if (need_wb) begin
            owner_d = cur_own;
            state_d = ST_WB;
          end else begin
            commit  = 1'b1;
            state_d = ST_GNT;
          end
        end
      end
      ST_WB: begin
        if (wb_ack) begin
          commit   = 1'b1;
          merge_wb = 1'b1;
          state_d  = ST_GNT;
        end
      end
      ST_GNT:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= ST_IDLE;
      core_q  <= '0;
      line_q  <= '0;
      op_q    <= '0;
      owner_q <= HOME;
      gpts_q  <= '0;
      gwts_q  <= '0;
      grts_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        core_q  <= core_d;
        line_q  <= line_d;
        op_q    <= op_d;
        owner_q <= owner_d;
      end
      if (commit) begin
        gpts_q <= nx_pts;
        gwts_q <= nx_wts;
        grts_q <= nx_rts;
      end
      if (commit && nx_ovf) err_q <= 1'b1;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign wb_req    = (state_q == ST_WB);
  assign wb_core   = owner_q;
  assign wb_line   = line_q;
  assign gnt_valid = (state_q == ST_GNT);
  assign gnt_core  = core_q;
  assign gnt_pts   = gpts_q;
  assign gnt_wts   = gwts_q;
  assign gnt_rts   = grts_q;
  assign ts_err    = err_q;

  AST_WB_HELD: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_core) && $stable(wb_line))); // R5
  AST_GNT_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wb_req && wb_ack) |=> gnt_valid); // R5
  AST_GNT_PULSE: assert property (@(posedge clk) disable iff (!rst_n_i)
    gnt_valid |=> !gnt_valid); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n_i)
    (gnt_valid || wb_req) |-> !req_ready); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n_i)
    ts_err |=> ts_err); // R8
  AST_WB_TARGET_REAL: assert property (@(posedge clk) disable iff (!rst_n_i)
    wb_req |-> (wb_core != HOME && wb_core != gnt_core)); // R10
  AST_READ_LEASE_AHEAD: assert property (@(posedge clk) disable iff (!rst_n_i)
    (gnt_valid && op_q != OP_WRITE && !ts_err) |-> (gnt_rts > gnt_pts)); // R2
  AST_WRITE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n_i)
    (gnt_valid && op_q == OP_WRITE) |-> (gnt_wts == gnt_pts && gnt_rts == gnt_pts)); // R4
endmodule

// File: tb/tsc_lease_mgr_tb.sv
module tsc_lease_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int NL = 8;
  localparam int LEASE = 10;
  localparam int TSMAX = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_core = '0;
  logic [2:0]  req_line = '0;
  logic [1:0]  req_op = '0;
  logic        wb_req;
  logic [2:0]  wb_core;
  logic [2:0]  wb_line;
  logic        wb_ack = 1'b0;
  logic        gnt_valid;
  logic [2:0]  gnt_core;
  logic [15:0] gnt_pts, gnt_wts, gnt_rts;
  logic        ts_err;

  int errors = 0;
  int checks = 0;

  // behavioural reference state
  int m_pts [NC];
  int m_wts [NL];
  int m_rts [NL];
  int m_own [NL];
  bit m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  tsc_lease_mgr #(.NUM_CORES(NC), .NUM_LINES(NL), .TS_W(16), .LEASE(LEASE)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_line(req_line), .req_op(req_op),
    .wb_req(wb_req), .wb_core(wb_core), .wb_line(wb_line), .wb_ack(wb_ack),
    .gnt_valid(gnt_valid), .gnt_core(gnt_core),
    .gnt_pts(gnt_pts), .gnt_wts(gnt_wts), .gnt_rts(gnt_rts),
    .ts_err(ts_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int sat(input int v);
    if (v > TSMAX) begin
      m_err = 1'b1;
      return TSMAX;
    end
    return v;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic txn(input int c, input int l, input int op, input int dly);
    bit    exp_wb;
    int    wbc, np, nr;
    string tag;
    tag    = (op == 1) ? "R4" : ((op == 2) ? "R3" : "R2");
    exp_wb = (m_own[l] != -1) && (m_own[l] != c);
    wbc    = m_own[l];
    if (exp_wb) begin
      m_wts[l] = m_pts[wbc];
      m_rts[l] = imax(m_rts[l], m_pts[wbc]);
      m_own[l] = -1;
    end
    if (op == 1) begin
      np = imax(m_pts[c], sat(m_rts[l] + 1));
      m_pts[c] = np; m_wts[l] = np; m_rts[l] = np; m_own[l] = c;
    end else begin
      np = imax(m_pts[c], m_wts[l]);
      nr = imax(m_rts[l], sat(np + LEASE));
      m_pts[c] = np; m_rts[l] = nr;
    end

    @(negedge clk);
    chk(req_ready == 1'b1, "R7 ready when idle", int'(req_ready), 1);
    chk(gnt_valid == 1'b0, "R7 grant single pulse", int'(gnt_valid), 0);
    req_valid = 1'b1; req_core = 3'(c); req_line = 3'(l); req_op = 2'(op);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_wb) begin
      chk(wb_req == 1'b1, "R5 writeback raised", int'(wb_req), 1);
      chk(int'(wb_core) == wbc, "R5 R10 writeback owner", int'(wb_core), wbc);
      chk(int'(wb_line) == l, "R5 writeback line", int'(wb_line), l);
      chk(gnt_valid == 1'b0, "R5 grant waits for ack", int'(gnt_valid), 0);
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        chk(wb_req == 1'b1 && gnt_valid == 1'b0, "R5 writeback held", int'(wb_req), 1);
      end
      wb_ack = 1'b1;
      @(negedge clk);
      wb_ack = 1'b0;
    end else begin
      chk(wb_req == 1'b0, "R6 no writeback", int'(wb_req), 0);
    end
    chk(gnt_valid == 1'b1, "R7 grant timing", int'(gnt_valid), 1);
    chk(req_ready == 1'b0, "R7 one outstanding", int'(req_ready), 0);
    chk(wb_req == 1'b0, "R5 writeback dropped at grant", int'(wb_req), 0);
    chk(int'(gnt_core) == c, {tag, " grant core"}, int'(gnt_core), c);
    chk(int'(gnt_pts) == np, {tag, " grant pts"}, int'(gnt_pts), np);
    chk(int'(gnt_wts) == m_wts[l], {tag, " grant wts"}, int'(gnt_wts), m_wts[l]);
    chk(int'(gnt_rts) == m_rts[l], {tag, " grant rts"}, int'(gnt_rts), m_rts[l]);
    chk(ts_err == m_err, "R8 error flag", int'(ts_err), int'(m_err));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R7 watchdog expired: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) m_pts[i] = 0;
    for (int i = 0; i < NL; i++) begin m_wts[i] = 0; m_rts[i] = 0; m_own[i] = -1; end
    m_err = 1'b0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state at the ports
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(gnt_valid == 1'b0, "R1 no grant after reset", int'(gnt_valid), 0);
    chk(wb_req == 1'b0, "R1 no writeback after reset", int'(wb_req), 0);
    chk(ts_err == 1'b0, "R1 no error after reset", int'(ts_err), 0);

    // R1: first reads see all-zero timestamps
    txn(1, 2, 0, 0);   // pts 0, wts 0, rts 10
    txn(2, 2, 0, 0);
    txn(0, 4, 2, 0);   // R3 renewal on fresh line
    // R4: writer jumps past outstanding lease, no invalidation (R6)
    txn(3, 2, 1, 0);   // pts 11
    txn(3, 2, 1, 0);   // R6 self-owned rewrite, pts 12
    txn(3, 2, 0, 0);   // R6 owner read, no writeback
    // R5: renewal by a stale reader pulls it forward through a writeback
    txn(1, 2, 2, 2);
    txn(2, 2, 0, 0);   // line now unowned: no writeback
    // R5: write steals ownership from another core
    txn(0, 5, 1, 0);
    txn(2, 5, 1, 3);
    txn(0, 5, 0, 1);
    // mixed lines and cores
    txn(1, 0, 1, 0);
    txn(3, 0, 2, 0);
    txn(3, 7, 0, 0);

    // R8: climb to saturation on one line
    while (!m_err) begin
      txn(0, 6, 1, 0);
      txn(0, 6, 0, 0);
    end
    txn(0, 6, 1, 0);
    txn(1, 6, 0, 4);
    chk(ts_err == 1'b1, "R8 error sticky", int'(ts_err), 1);

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule